// File: doc/BRIEF.md
# Back Channel GPIO Sampler

This block sits on the return path of a serial link. It watches up to four general-purpose input pins, takes snapshots of them at evenly spaced moments, and packs those snapshots into a fixed frame of 32 bit-times. The frame goes out one bit per bit-time. An oscillator clock drives everything. A divider of 1, 2 or 4 turns that clock into a bit-rate enable. Divide by 4 gives the nominal 5 Mbps rate, divide by 2 gives 10 Mbps and divide by 1 gives 20 Mbps.

A three-bit mode input chooses how many pins are carried and how many snapshots of them each frame holds. More snapshots of fewer pins give a higher effective sampling rate per pin. Each frame carries the snapshots taken during the previous frame. This double buffering lets sampling spread evenly over the whole frame while the payload still leaves at the front of the frame. The mode and divider inputs are taken only at a frame boundary. A high-speed enable, or a strap input captured while reset is held, forces divide-by-1 and takes priority over the divider select.

Top module: `bcGpioSampler`

## Requirements
- R1: While `rstN` is low, `bitEn`, `frameStart`, `txValid` and `txBit` are all low. The first bit-time after reset is released comes one clock after release and is a frame start. That first frame carries no payload.
- R2: With the high-speed override inactive, `bitEn` pulses every 4 oscillator clocks when `divSel` is 0 and every 2 clocks when `divSel` is 1.
- R3: When `hsEn` is 1, `bitEn` pulses on every oscillator clock, whatever the value of `divSel`.
- R4: A frame is exactly 32 bit-times. `frameStart` is high only together with the `bitEn` pulse of a frame's first bit-time.
- R5: Mode encodings: 000 carries 4 pins with 1 sample per frame. 011 carries 4 pins with 6 samples. 010 carries pins 1:0 with 10 samples. 001 carries pin 0 with 15 samples. Encodings 100 to 111 behave as 000.
- R6: A frame's payload occupies bit-times 0 to P-1, where P = pins × samples. Within one sample the pins go out lowest index first, and samples go out in time order. During these bit-times `txValid` is high. In every later bit-time of the frame both `txValid` and `txBit` are low.
- R7: Samples are taken at bit-times whose index within the frame is a multiple of floor(32 / samples), starting at index 0. At most `samples` are taken per frame. Each sample captures the pin value present at the clock edge that raises `bitEn` for that bit-time.
- R8: The samples taken during one frame are sent in the next frame, with the payload length of the mode under which they were taken.
- R9: Changes on `modeSel`, `divSel` or `hsEn` during a frame affect neither that frame's bit-time spacing nor its sampling. They take effect from the next frame start.
- R10: The value on `strapHs` while `rstN` is low is retained after reset. When that retained value is 1, it forces divide-by-1 exactly as `hsEn` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Synchronous active-low reset |
| strapHs | input | 1 | High-speed strap, captured while reset is held |
| gpio | input | 4 | Pins to be sampled |
| modeSel | input | 3 | Pin count and samples-per-frame selection |
| divSel | input | 1 | Divider select: 0 = divide by 4, 1 = divide by 2 |
| hsEn | input | 1 | High-speed enable, forces divide by 1 |
| bitEn | output | 1 | One-clock pulse per bit-time |
| txBit | output | 1 | Serial payload bit, valid with `bitEn` |
| txValid | output | 1 | High on bit-times that carry payload |
| frameStart | output | 1 | High on the first bit-time of a frame |

## Verification
The assertions take the outputs and the control strobes to be meaningful only after the first clock edge following reset. They also assume the pins and settings are synchronous to the oscillator clock, so a sample or a frame-boundary load never sees a value in transition. The stimulus respects both assumptions. It changes pins and settings only on the falling edge, right after the bench has seen a `bitEn`. Settings are changed partway through a frame, so the frame-boundary rule is exercised against a frame already in flight.

// File: rtl/bcGpioPkg.sv
package bcGpioPkg;

  parameter int FRAME_SLOTS = 32;
  parameter int NUM_PINS    = 4;
  parameter int MAX_PAYLOAD = 24;

  typedef enum logic [2:0] {
    M_NORMAL = 3'b000,
    M_FAST1  = 3'b001,
    M_FAST2  = 3'b010,
    M_FAST4  = 3'b011
  } modeT;

  typedef struct packed {
    logic       tick;       // bit-time boundary this cycle
    logic       frameTick;  // boundary that opens a new frame
    logic       sample;     // take a pin snapshot at this boundary
    logic [3:0] sampIdx;    // index of that snapshot within the frame
    modeT       effMode;    // mode governing this boundary
  } bcStrobeT;

  function automatic modeT decodeMode(input logic [2:0] raw);
    case (raw)
      3'b001:  return M_FAST1;
      3'b010:  return M_FAST2;
      3'b011:  return M_FAST4;
      default: return M_NORMAL;
    endcase
  endfunction

  function automatic logic [2:0] pinsOf(input modeT m);
    case (m)
      M_FAST1: return 3'd1;
      M_FAST2: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [3:0] samplesOf(input modeT m);
    case (m)
      M_FAST1: return 4'd15;
      M_FAST2: return 4'd10;
      M_FAST4: return 4'd6;
      default: return 4'd1;
    endcase
  endfunction

  function automatic logic [4:0] payloadOf(input modeT m);
    return 5'(5'(pinsOf(m)) * 5'(samplesOf(m)));
  endfunction

  function automatic int spacingOf(input modeT m, input int slots);
    return slots / int'(samplesOf(m));
  endfunction

endpackage

// File: rtl/bcGpioCtrl.sv
module bcGpioCtrl
  import bcGpioPkg::*;
#(
  parameter int SLOTS = FRAME_SLOTS
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       strapHs,
  input  logic [2:0] modeSel,
  input  logic       divSel,
  input  logic       hsEn,
  output bcStrobeT   ctl
);

  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int PHASE_W = SLOT_W + 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic [1:0]         divCnt;
  logic [1:0]         actDivLog;
  logic [1:0]         newDivLog;
  logic [1:0]         divLimit;
  logic [SLOT_W-1:0]  slot;
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] nextPhase;
  logic [PHASE_W-1:0] spacingM1;
  logic [3:0]         sampCount;
  logic [3:0]         sampIdxNext;
  logic               strapLatch;
  modeT               actMode;
  modeT               newMode;
  modeT               effMode;
  logic               tick;
  logic               frameTick;
  logic               sample;

  // strap is captured on every edge while reset is held, then frozen
  always_ff @(posedge clk) begin
    if (!rstN) strapLatch <= strapHs;
  end

  // high-speed override wins over the divider select
  always_comb begin
    if (hsEn || strapLatch) newDivLog = 2'd0;
    else if (divSel)        newDivLog = 2'd1;
    else                    newDivLog = 2'd2;
  end

  always_comb begin
    case (actDivLog)
      2'd0:    divLimit = 2'd0;
      2'd1:    divLimit = 2'd1;
      default: divLimit = 2'd3;
    endcase
  end

  assign tick      = (divCnt == divLimit);
  assign frameTick = tick && (slot == LAST_SLOT);
  assign newMode   = decodeMode(modeSel);
  assign effMode   = frameTick ? newMode : actMode;
  assign spacingM1 = PHASE_W'(spacingOf(effMode, SLOTS) - 1);

  always_comb begin
    if (frameTick)               nextPhase = '0;
    else if (phase == spacingM1) nextPhase = '0;
    else                         nextPhase = phase + 1'b1;
  end

  assign sampIdxNext = frameTick ? 4'd0 : sampCount;
  assign sample      = tick && (nextPhase == '0) && (sampIdxNext < samplesOf(effMode));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt    <= '0;
      actDivLog <= 2'd0;
      slot      <= LAST_SLOT;
      phase     <= '0;
      sampCount <= '0;
      actMode   <= M_NORMAL;
    end else if (tick) begin
      divCnt <= '0;
      slot   <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
      phase  <= nextPhase;
      if (sample) sampCount <= sampIdxNext + 4'd1;
      if (frameTick) begin
        actMode   <= newMode;
        actDivLog <= newDivLog;
      end
    end else begin
      divCnt <= divCnt + 2'd1;
    end
  end

  always_comb begin
    ctl.tick      = tick;
    ctl.frameTick = frameTick;
    ctl.sample    = sample;
    ctl.sampIdx   = sampIdxNext;
    ctl.effMode   = effMode;
  end

  // R4: two frame boundaries never fall on back-to-back clocks
  p_frame_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    frameTick |=> !frameTick);

  // R2: inside a frame, a divided rate never yields two adjacent ticks
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !frameTick && actDivLog != 2'd0) |=> !tick);

endmodule

// File: rtl/bcGpioPath.sv
module bcGpioPath
  import bcGpioPkg::*;
#(
  parameter int PINS    = NUM_PINS,
  parameter int PAYLOAD = MAX_PAYLOAD
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PINS-1:0] gpio,
  input  bcStrobeT        ctl,
  output logic            bitEn,
  output logic            txBit,
  output logic            txValid,
  output logic            frameStart
);

  localparam int LEN_W  = $clog2(PAYLOAD + 1);
  localparam int BASE_W = $clog2(PAYLOAD) + 1;

  logic [PAYLOAD-1:0] capture;
  logic [PAYLOAD-1:0] shiftReg;
  logic [PAYLOAD-1:0] placed;
  logic [LEN_W-1:0]   capLen;
  logic [LEN_W-1:0]   remain;
  logic [PINS-1:0]    pinMask;
  logic [BASE_W-1:0]  base;
  logic [2:0]         pinCnt;

  assign pinCnt = pinsOf(ctl.effMode);

  for (genvar i = 0; i < PINS; i++) begin : g_mask
    assign pinMask[i] = (32'(i) < 32'(pinCnt));
  end

  assign base   = BASE_W'(BASE_W'(ctl.sampIdx) * BASE_W'(pinCnt));
  assign placed = PAYLOAD'(gpio & pinMask) << base;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capture    <= '0;
      shiftReg   <= '0;
      capLen     <= '0;
      remain     <= '0;
      bitEn      <= 1'b0;
      txBit      <= 1'b0;
      txValid    <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      bitEn      <= ctl.tick;
      frameStart <= ctl.frameTick;
      if (ctl.frameTick) begin
        // hand the finished capture to the shifter, start a fresh capture
        shiftReg <= capture >> 1;
        txValid  <= (capLen != '0);
        txBit    <= (capLen != '0) && capture[0];
        remain   <= (capLen != '0) ? capLen - 1'b1 : '0;
        capLen   <= LEN_W'(payloadOf(ctl.effMode));
        capture  <= ctl.sample ? placed : '0;
      end else if (ctl.tick) begin
        txValid  <= (remain != '0);
        txBit    <= (remain != '0) && shiftReg[0];
        shiftReg <= shiftReg >> 1;
        if (remain != '0) remain <= remain - 1'b1;
        if (ctl.sample) capture <= capture | placed;
      end else begin
        txValid <= 1'b0;
        txBit   <= 1'b0;
      end
    end
  end

  // R4: a frame start always coincides with a bit-time
  p_start_on_bit_r4: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> bitEn);

  // R6: payload is only ever flagged on a bit-time
  p_valid_on_bit_r6: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> bitEn);

  // R6: slots without payload carry zero
  p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rstN)
    !txValid |-> !txBit);

  // R7: the control never asks for more snapshots than the mode holds
  p_sample_in_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sample |-> (ctl.sampIdx < samplesOf(ctl.effMode)));

  // R8: bits left to send never exceed the largest payload
  p_remain_cap_r8: assert property (@(posedge clk) disable iff (!rstN)
    remain <= LEN_W'(PAYLOAD));

endmodule

// File: rtl/bcGpioSampler.sv
module bcGpioSampler
  import bcGpioPkg::*;
#(
  parameter int SLOTS   = FRAME_SLOTS,
  parameter int PINS    = NUM_PINS,
  parameter int PAYLOAD = MAX_PAYLOAD
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            strapHs,
  input  logic [PINS-1:0] gpio,
  input  logic [2:0]      modeSel,
  input  logic            divSel,
  input  logic            hsEn,
  output logic            bitEn,
  output logic            txBit,
  output logic            txValid,
  output logic            frameStart
);

  bcStrobeT ctl;

  bcGpioCtrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .strapHs (strapHs),
    .modeSel (modeSel),
    .divSel  (divSel),
    .hsEn    (hsEn),
    .ctl     (ctl)
  );

  bcGpioPath #(.PINS(PINS), .PAYLOAD(PAYLOAD)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .gpio       (gpio),
    .ctl        (ctl),
    .bitEn      (bitEn),
    .txBit      (txBit),
    .txValid    (txValid),
    .frameStart (frameStart)
  );

endmodule

// File: tb/bcGpioSampler_test.sv
`timescale 1ns/1ps
module bcGpioSampler_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       strapHs = 1'b0;
  logic [3:0] gpio = 4'd0;
  logic [2:0] modeSel = 3'd0;
  logic       divSel = 1'b0;
  logic       hsEn = 1'b0;
  logic       bitEn, txBit, txValid, frameStart;

  int   checks = 0;
  int   errors = 0;
  bit   atStart = 0;
  logic strapExp = 1'b0;
  int   prevLen = 0;
  int   prevNp = 1;
  logic [3:0] prevSamp [16];

  always #2.5 clk = ~clk;

  bcGpioSampler uut (
    .clk(clk), .rstN(rstN), .strapHs(strapHs), .gpio(gpio),
    .modeSel(modeSel), .divSel(divSel), .hsEn(hsEn),
    .bitEn(bitEn), .txBit(txBit), .txValid(txValid), .frameStart(frameStart)
  );

  function automatic int pinsFor(input logic [2:0] m);
    case (m)
      3'b001:  return 1;
      3'b010:  return 2;
      default: return 4;
    endcase
  endfunction

  function automatic int samplesFor(input logic [2:0] m);
    case (m)
      3'b001:  return 15;
      3'b010:  return 10;
      3'b011:  return 6;
      default: return 1;
    endcase
  endfunction

  function automatic int divNow();
    if (hsEn || strapExp) return 1;
    return divSel ? 2 : 4;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset(input logic strap, input logic [2:0] m,
                         input logic d, input logic h);
    rstN = 1'b0; strapHs = strap; modeSel = m; divSel = d; hsEn = h; gpio = 4'd0;
    repeat (3) @(negedge clk);
    chk({bitEn, frameStart, txValid, txBit} == 4'b0, "R1", "outputs in reset",
        {bitEn, frameStart, txValid, txBit}, 0);
    rstN = 1'b1;
    strapExp = strap;
    @(negedge clk);
    chk(bitEn && frameStart, "R1", "first bit-time is frame start",
        {bitEn, frameStart}, 2'b11);
    strapHs = 1'b0;
    atStart = 1;
    prevLen = 0;
  endtask

  // Runs one frame; settings change after bit-time chgSlot (-1: none)
  task automatic runFrame(input int chgSlot, input logic [2:0] nMode,
                          input logic nDiv, input logic nHs, input string gapReq);
    logic [2:0]  fMode;
    logic [31:0] gotB, gotV, expB, expV;
    logic [3:0]  samp [16];
    int expDiv, np, ns, sp, gap, badGap, badStart;
    if (!atStart) begin
      do @(negedge clk); while (!(bitEn && frameStart));
    end
    atStart = 0;
    fMode = modeSel; expDiv = divNow();
    np = pinsFor(fMode); ns = samplesFor(fMode); sp = 32 / ns;
    gotB = '0; gotV = '0; badGap = 0; badStart = 0;
    for (int i = 0; i < 16; i++) samp[i] = 4'd0;
    for (int s = 0; s < 32; s++) begin
      if (s > 0) begin
        gap = 0;
        do begin @(negedge clk); gap++; end while (!bitEn);
        if (gap != expDiv) badGap++;
        if (frameStart) badStart++;
      end
      gotB[s] = txBit; gotV[s] = txValid;
      if ((s % sp) == 0 && (s / sp) < ns) samp[s / sp] = gpio;
      if (s == chgSlot) begin modeSel = nMode; divSel = nDiv; hsEn = nHs; end
      gpio = 4'($urandom);
    end
    expB = '0; expV = '0;
    for (int k = 0; k < prevLen; k++) begin
      expV[k] = 1'b1;
      expB[k] = prevSamp[k / prevNp][k % prevNp];
    end
    chk(badGap == 0, gapReq, "bit-time spacing errors", badGap, 0);
    chk(badStart == 0, "R4", "stray frame starts", badStart, 0);
    chk(gotV == expV, "R5/R6/R8", "valid slots", gotV, expV);
    chk(gotB == expB, "R6/R7/R8", "payload bits", gotB, expB);
    prevLen = np * ns; prevNp = np;
    for (int i = 0; i < 16; i++) prevSamp[i] = samp[i];
  endtask

  task automatic testResetAndNormal();
    doReset(1'b0, 3'b000, 1'b0, 1'b0);
    runFrame(-1, 3'b000, 1'b0, 1'b0, "R2");  // R1: empty first frame
    runFrame(-1, 3'b000, 1'b0, 1'b0, "R2");
  endtask

  task automatic testFast4Div2();
    runFrame(7, 3'b011, 1'b1, 1'b0, "R9");   // R9: old settings hold
    runFrame(-1, 3'b011, 1'b1, 1'b0, "R2");
    runFrame(-1, 3'b011, 1'b1, 1'b0, "R2");
  endtask

  task automatic testFast2HighSpeed();
    runFrame(20, 3'b010, 1'b0, 1'b1, "R9");
    runFrame(-1, 3'b010, 1'b0, 1'b1, "R3");
    runFrame(-1, 3'b010, 1'b0, 1'b1, "R3");
  endtask

  task automatic testFast1Div2();
    runFrame(3, 3'b001, 1'b1, 1'b0, "R9");
    runFrame(-1, 3'b001, 1'b1, 1'b0, "R2");
    runFrame(-1, 3'b001, 1'b1, 1'b0, "R2");
  endtask

  task automatic testReservedMode();
    runFrame(12, 3'b110, 1'b0, 1'b0, "R9");  // R5: reserved acts as normal
    runFrame(-1, 3'b110, 1'b0, 1'b0, "R2");
    runFrame(-1, 3'b101, 1'b0, 1'b0, "R2");
  endtask

  task automatic testStrap();
    doReset(1'b1, 3'b001, 1'b0, 1'b0);
    runFrame(-1, 3'b001, 1'b0, 1'b0, "R10");
    runFrame(-1, 3'b001, 1'b0, 1'b0, "R10");
  endtask

  initial begin
    testResetAndNormal();
    testFast4Div2();
    testFast2HighSpeed();
    testFast1Div2();
    testReservedMode();
    testStrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule